// File: doc/BRIEF.md
# Bidirectional Pad Function Multiplexer

This block sits between a row of IO pad cells and a set of peripheral signal functions. Every pad owns a small selection register. The value in that register decides which peripheral function the pad is joined to. Three things follow the selection together: the value driven out of the pad, the pad's output-enable, and the path that carries the pad's sampled input back to a peripheral. General-purpose IO is one more function in the table, with its own out, in and enable signals, and is treated like any other function.

Each function is declared input-only, output-only or bidirectional through a parameter. An output-only function forces its pad's enable high. An input-only function forces the enable low. A bidirectional function supplies its own enable. Any route with no selected driver is tied to constant zero. A small register front end writes and reads the selection registers. It decodes a slice of the address as the register index and reports an error flag for an index that has no register.

Top module: `pinmux_xbar`

## Requirements
- R1: After reset every selection register holds zero. In that state every pad_o and pad_oe bit is low, and every fn_in bit is low whatever pad_i carries.
- R2: The register index is wr_addr[ADDR_W-1:IDX_LSB]. The low IDX_LSB address bits are ignored. When wr_en is high and the index is below NUM_PADS, that pad's register takes wr_data[SEL_W-1:0] at the next rising clock edge, and the upper data bits are dropped.
- R3: When the write index is NUM_PADS or above, wr_err is high. A write to such an index changes no register.
- R4: For a mapped rd_addr index, rd_data is the register value zero-extended to DATA_W and rd_err is low. For an unmapped index, rd_err is high and rd_data is zero. The read path is combinational.
- R5: Selection code 0 and any code above NUM_FUNCS leave the pad unrouted, with pad_o and pad_oe both low. A code c from 1 to NUM_FUNCS selects function c-1. The kind of function f is FUNC_KIND[2f+1:2f]: 01 means input-only, 10 means output-only and 11 means bidirectional.
- R6: A pad that selects an output-only function drives pad_o from that function's fn_out, with pad_oe high.
- R7: A pad that selects an input-only function has pad_o and pad_oe low, and its pad_i is delivered to that function's fn_in.
- R8: A pad that selects a bidirectional function drives pad_o from fn_out and pad_oe from fn_oe, and its pad_i is delivered to that function's fn_in.
- R9: fn_in of a function is zero when no pad selects it, and it is always zero for an output-only function.
- R10: When several pads select the same input-capable function, fn_in follows the lowest-numbered of those pads.
- R11: Registers change only on a mapped write. Pad and function outputs follow the register contents combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address; index in the upper bits |
| wr_data | input | DATA_W | Write data; low SEL_W bits are kept |
| wr_err | output | 1 | Write index has no register |
| rd_addr | input | ADDR_W | Read address; index in the upper bits |
| rd_data | output | DATA_W | Zero-extended selection value |
| rd_err | output | 1 | Read index has no register |
| pad_i | input | NUM_PADS | Values sampled from the pads |
| pad_o | output | NUM_PADS | Values driven toward the pads |
| pad_oe | output | NUM_PADS | Output-enables toward the pads |
| fn_out | input | NUM_FUNCS | Output value of each function |
| fn_oe | input | NUM_FUNCS | Enable of each function (used by bidirectional kinds) |
| fn_in | output | NUM_FUNCS | Input value delivered to each function |

## Verification
The assertions check the following on every cycle: that a mapped write lands in the addressed register, that unmapped writes and idle cycles leave every register untouched, that an erroring read returns zero, that unrouted codes keep the pad quiet, and that output-only selections raise the enable. The lowest-pad priority on shared inputs, the zero fallback for unselected functions, and the exact data and enable steering for every kind can only be shown by the bench. It sweeps every combination of codes on all four pads under varied pad and function stimulus. The bench also covers the reset state, dropped address and data bits, and the full unmapped index range.

// File: rtl/pinmux_pkg.sv
// Shared encodings for the pad function multiplexer.
// Assumes function kinds are packed two bits per function in a parameter vector.
package pinmux_pkg;

    typedef enum logic [1:0] {
        FK_NONE  = 2'b00,
        FK_IN    = 2'b01,
        FK_OUT   = 2'b10,
        FK_BIDIR = 2'b11
    } func_kind_e;

    // True when a function kind samples the pad.
    function automatic logic kind_samples(input logic [1:0] k);
        return (k == FK_IN) || (k == FK_BIDIR);
    endfunction

endpackage

// File: rtl/pmx_sel_regs.sv
// Selection register bank with index-decoded write and read access.
// Assumes the register index sits in addr[ADDR_W-1:IDX_LSB]; writes land
// on the next clock edge, reads are combinational.
module pmx_sel_regs #(
    parameter int NUM_PADS = 4,
    parameter int SEL_W    = 3,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int IDX_LSB  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    output logic                           wr_err,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_data,
    output logic                           rd_err,
    output logic [NUM_PADS-1:0][SEL_W-1:0] sel_q
);
    localparam int IDX_W = ADDR_W - IDX_LSB;

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             wr_hit;

    assign wr_idx = wr_addr[ADDR_W-1:IDX_LSB];
    assign rd_idx = rd_addr[ADDR_W-1:IDX_LSB];
    assign wr_hit = 32'(wr_idx) < NUM_PADS;
    assign wr_err = !wr_hit;

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_reg
        // Hold one pad's selection; load it on a matching mapped write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[p] <= '0;
            else if (wr_en && wr_hit && (wr_idx == IDX_W'(p)))
                sel_q[p] <= wr_data[SEL_W-1:0];
        end
    end

    // Return the indexed register zero-extended, or an error with zero data.
    always_comb begin
        rd_data = '0;
        rd_err  = 1'b1;
        for (int i = 0; i < NUM_PADS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = DATA_W'(sel_q[i]);
                rd_err  = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pmx_pad_route.sv
// Steers one pad: picks pad data and enable from the selected function and
// marks which function, if any, this pad's input serves.
// Assumes code 0 and codes above NUM_FUNCS are unrouted.
module pmx_pad_route
    import pinmux_pkg::*;
#(
    parameter int                     NUM_FUNCS = 6,
    parameter int                     SEL_W     = 3,
    parameter logic [2*NUM_FUNCS-1:0] FUNC_KIND = '0
) (
    input  logic [SEL_W-1:0]     sel,
    input  logic [NUM_FUNCS-1:0] fn_out,
    input  logic [NUM_FUNCS-1:0] fn_oe,
    output logic                 pad_o,
    output logic                 pad_oe,
    output logic [NUM_FUNCS-1:0] claim
);
    // Decode the selection into data, enable and input claim.
    always_comb begin
        pad_o  = 1'b0;
        pad_oe = 1'b0;
        claim  = '0;
        for (int f = 0; f < NUM_FUNCS; f++) begin
            if (sel == SEL_W'(f + 1)) begin
                case (FUNC_KIND[2*f +: 2])
                    FK_OUT: begin
                        pad_o  = fn_out[f];
                        pad_oe = 1'b1;
                    end
                    FK_BIDIR: begin
                        pad_o  = fn_out[f];
                        pad_oe = fn_oe[f];
                    end
                    default: begin
                        pad_o  = 1'b0;
                        pad_oe = 1'b0;
                    end
                endcase
                claim[f] = kind_samples(FUNC_KIND[2*f +: 2]);
            end
        end
    end

endmodule

// File: rtl/pmx_func_return.sv
// Gathers pad inputs back to functions; lowest-numbered claiming pad wins,
// unclaimed functions see zero.
module pmx_func_return #(
    parameter int NUM_PADS  = 4,
    parameter int NUM_FUNCS = 6
) (
    input  logic [NUM_PADS-1:0][NUM_FUNCS-1:0] claim,
    input  logic [NUM_PADS-1:0]                pad_i,
    output logic [NUM_FUNCS-1:0]               fn_in
);
    // Scan pads from highest to lowest so the lowest claimant is applied last.
    always_comb begin
        fn_in = '0;
        for (int f = 0; f < NUM_FUNCS; f++) begin
            for (int p = NUM_PADS - 1; p >= 0; p--) begin
                if (claim[p][f])
                    fn_in[f] = pad_i[p];
            end
        end
    end

endmodule

// File: rtl/pinmux_xbar.sv
// Top of the pad function multiplexer: selection registers, per-pad
// steering and input return. Assumes NUM_FUNCS+1 codes fit in SEL_W bits.
module pinmux_xbar #(
    parameter int                     NUM_PADS  = 4,
    parameter int                     NUM_FUNCS = 6,
    parameter logic [2*NUM_FUNCS-1:0] FUNC_KIND = 12'hE79,
    parameter int                     ADDR_W    = 8,
    parameter int                     DATA_W    = 32,
    parameter int                     IDX_LSB   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic                 wr_err,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_err,
    input  logic [NUM_PADS-1:0]  pad_i,
    output logic [NUM_PADS-1:0]  pad_o,
    output logic [NUM_PADS-1:0]  pad_oe,
    input  logic [NUM_FUNCS-1:0] fn_out,
    input  logic [NUM_FUNCS-1:0] fn_oe,
    output logic [NUM_FUNCS-1:0] fn_in
);
    localparam int SEL_W = $clog2(NUM_FUNCS + 1);

    logic [NUM_PADS-1:0][SEL_W-1:0]     sel_q;
    logic [NUM_PADS-1:0][NUM_FUNCS-1:0] claim;

    pmx_sel_regs #(
        .NUM_PADS(NUM_PADS), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .IDX_LSB(IDX_LSB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_err(rd_err),
        .sel_q(sel_q)
    );

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        pmx_pad_route #(
            .NUM_FUNCS(NUM_FUNCS), .SEL_W(SEL_W), .FUNC_KIND(FUNC_KIND)
        ) u_route (
            .sel(sel_q[p]), .fn_out(fn_out), .fn_oe(fn_oe),
            .pad_o(pad_o[p]), .pad_oe(pad_oe[p]), .claim(claim[p])
        );
    end

    pmx_func_return #(
        .NUM_PADS(NUM_PADS), .NUM_FUNCS(NUM_FUNCS)
    ) u_return (
        .claim(claim), .pad_i(pad_i), .fn_in(fn_in)
    );

endmodule

// File: rtl/pmx_checker.sv
// Cycle-level properties of the pad function multiplexer, bound to the top.
module pmx_checker #(
    parameter int                     NUM_PADS  = 4,
    parameter int                     NUM_FUNCS = 6,
    parameter logic [2*NUM_FUNCS-1:0] FUNC_KIND = '0,
    parameter int                     SEL_W     = 3,
    parameter int                     ADDR_W    = 8,
    parameter int                     DATA_W    = 32,
    parameter int                     IDX_LSB   = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wr_en,
    input logic [ADDR_W-1:0]              wr_addr,
    input logic [DATA_W-1:0]              wr_data,
    input logic                           wr_err,
    input logic [DATA_W-1:0]              rd_data,
    input logic                           rd_err,
    input logic [NUM_PADS-1:0][SEL_W-1:0] sel_q,
    input logic [NUM_PADS-1:0]            pad_o,
    input logic [NUM_PADS-1:0]            pad_oe
);
    localparam int IDX_W = ADDR_W - IDX_LSB;

    assert_bad_write_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_err) |=> $stable(sel_q));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel_q));

    assert_rd_err_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == '0));

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        logic       valid_p;
        logic [1:0] kind_p;

        // Look up the kind of the function this pad currently selects.
        always_comb begin
            valid_p = (sel_q[p] != '0) && (32'(sel_q[p]) <= NUM_FUNCS);
            kind_p  = valid_p ? FUNC_KIND[2*(32'(sel_q[p]) - 1) +: 2] : 2'b00;
        end

        assert_write_stores_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_err && (wr_addr[ADDR_W-1:IDX_LSB] == IDX_W'(p)))
            |=> (sel_q[p] == $past(wr_data[SEL_W-1:0])));

        assert_unused_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_p |-> (!pad_o[p] && !pad_oe[p]));

        assert_out_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (kind_p == 2'b10) |-> pad_oe[p]);
    end

endmodule

bind pinmux_xbar pmx_checker #(
    .NUM_PADS(NUM_PADS), .NUM_FUNCS(NUM_FUNCS), .FUNC_KIND(FUNC_KIND),
    .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_LSB(IDX_LSB)
) u_pmx_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_err(wr_err), .rd_data(rd_data), .rd_err(rd_err),
    .sel_q(sel_q), .pad_o(pad_o), .pad_oe(pad_oe)
);

// File: tb/tb_pinmux_xbar.sv
`timescale 1ns/1ps
module tb_pinmux_xbar;
    localparam int NP = 4;
    localparam int NF = 6;
    // Function kinds from the default parameter: 1 in-only, 2 out-only, 3 bidir.
    localparam int KIND [NF] = '{1, 2, 3, 1, 2, 3};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          wr_err;
    logic [7:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic          rd_err;
    logic [NP-1:0] pad_i = '0;
    logic [NP-1:0] pad_o, pad_oe;
    logic [NF-1:0] fn_out = '0, fn_oe = '0;
    logic [NF-1:0] fn_in;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    int  codes [NP];

    pinmux_xbar dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_err(wr_err), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_err(rd_err), .pad_i(pad_i), .pad_o(pad_o),
        .pad_oe(pad_oe), .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input int idx, input int exp, input bit experr, input string tag);
        rd_addr = 8'(idx << 2);
        #1;
        check(rd_err == experr && rd_data == 32'(exp), tag, {rd_err, rd_data}, {experr, 32'(exp)});
    endtask

    // Expected routing from the requirements.
    task automatic model(output logic [NP-1:0] po, output logic [NP-1:0] poe, output logic [NF-1:0] fi);
        po = '0; poe = '0; fi = '0;
        for (int p = 0; p < NP; p++) begin
            int c = codes[p];
            if (c >= 1 && c <= NF) begin
                if (KIND[c-1] == 2) begin po[p] = fn_out[c-1]; poe[p] = 1'b1; end
                if (KIND[c-1] == 3) begin po[p] = fn_out[c-1]; poe[p] = fn_oe[c-1]; end
            end
        end
        for (int f = 0; f < NF; f++)
            for (int p = NP - 1; p >= 0; p--)
                if (codes[p] == f + 1 && KIND[f] != 2) fi[f] = pad_i[p];
    endtask

    task automatic route_check(input string tag);
        logic [NP-1:0] po, poe;
        logic [NF-1:0] fi;
        #1;
        model(po, poe, fi);
        check(pad_o == po && pad_oe == poe && fn_in == fi, tag,
              {pad_o, pad_oe, fn_in}, {po, poe, fi});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int p = 0; p < NP; p++) rd_check(p, 0, 1'b0, "R1 reset register");
        pad_i = '1; fn_out = '1; fn_oe = '1;
        #1;
        check(pad_o == '0 && pad_oe == '0 && fn_in == '0, "R1 reset outputs",
              {pad_o, pad_oe, fn_in}, 0);

        // R2: low address bits ignored, upper data bits dropped
        wr((1 << 2) | 3, 32'hFFFF_FFF9);
        rd_check(1, 1, 1'b0, "R2 truncate and low addr bits");
        wr(2 << 2, 32'h0000_0005);
        rd_check(2, 5, 1'b0, "R2 mapped write");

        // R3: unmapped writes flag an error and change nothing
        for (int i = NP; i < 64; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 8'(i << 2); wr_data = 32'h7;
            #1;
            check(wr_err == 1'b1, "R3 wr_err", wr_err, 1);
            @(negedge clk);
            wr_en = 1'b0;
        end
        rd_check(0, 0, 1'b0, "R3 pad0 unchanged");
        rd_check(1, 1, 1'b0, "R3 pad1 unchanged");
        rd_check(2, 5, 1'b0, "R3 pad2 unchanged");
        rd_check(3, 0, 1'b0, "R3 pad3 unchanged");

        // R4: unmapped reads
        for (int i = NP; i < 64; i++) rd_check(i, 0, 1'b1, "R4 unmapped read");

        // R10: pads 0 and 2 both choose in-only function 0; pad 0 wins
        wr(0 << 2, 1); wr(2 << 2, 1); wr(1 << 2, 0); wr(3 << 2, 0);
        pad_i = 4'b0100;
        #1;
        check(fn_in[0] == 1'b0, "R10 lowest pad wins (low)", fn_in[0], 0);
        pad_i = 4'b0001;
        #1;
        check(fn_in[0] == 1'b1, "R10 lowest pad wins (high)", fn_in[0], 1);

        // R5/R6/R7/R8/R9/R10/R11: every code combination on all pads
        for (int cfg = 0; cfg < (1 << (3 * NP)); cfg++) begin
            for (int p = 0; p < NP; p++) begin
                codes[p] = (cfg >> (3 * p)) & 7;
                wr(p << 2, {$urandom() & 32'hFFFF_FFF8} | 32'(codes[p]));
            end
            for (int k = 0; k < 3; k++) begin
                pad_i = NP'($urandom()); fn_out = NF'($urandom()); fn_oe = NF'($urandom());
                route_check("R5/R6/R7/R8/R9/R10/R11 sweep");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule